// File: doc/BRIEF.md
# Burst-Granular Priority Channel Arbiter

This block decides which channel of a multi-channel DMA controller owns the bus. It is a bus master arbiter. Each channel supplies several inputs: a single-request line, a burst-request line, an enable bit, a request-mask bit, a high-priority bit, a software-request pulse, a flag saying its peripheral supports single requests only, and a 4-bit burst exponent. The arbiter picks one pending channel and keeps the grant for a whole burst of data moves. It reports the granted index and pulses a start strobe each time a grant begins.

A datapath outside the block performs the data moves. For each completed move it raises the `move_done` strobe. The arbiter counts these strobes. It makes a new decision only when the last move of the current burst completes, or while it is idle.

A normal channel has a burst of 2^N moves, where N is that channel's exponent. A channel marked single-only has a burst of exactly one move. The winner is chosen first from the high-priority group and then from the normal group. Inside each group the lowest index wins. A software request is stored until the burst it asked for begins. The request mask blocks the peripheral request lines but never blocks the software request.

Top module: `burst_prio_arbiter`

## Requirements
- R1: After reset, grant_valid, grant_idx and burst_start are all 0.
- R2: When no high-priority bit is set, an arbitration grants the pending channel with the lowest index.
- R3: A pending channel whose high-priority bit is 1 beats every pending channel whose bit is 0. Among high-priority channels, the lowest index wins.
- R4: A granted channel keeps grant_idx unchanged until the 2^N-th `move_done` strobe of its burst (N = its exponent). The next grant decision is taken on the clock edge of that strobe.
- R5: If the channel that just finished a burst is still the best pending channel, it is granted again, and burst_start pulses again.
- R6: For a channel whose single_only bit is 1, the burst is one move whatever its exponent is.
- R7: When a channel's mask bit is 1, its single-request and burst-request lines are not seen as pending.
- R8: A software-request pulse makes its channel pending even when the channel is masked. The request stays pending until that channel's burst starts, so one pulse produces exactly one burst.
- R9: A channel whose enable bit is 0 is never granted. This holds for every kind of request.
- R10: When an arbitration finds nothing pending, grant_valid is 0 from the next cycle on, and grant_idx reads 0 while grant_valid is 0.
- R11: burst_start is 1 for exactly the first cycle of each grant. That grant is registered one clock after the arbitration cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NUM_CH | Enable bit, one per channel |
| req_mask | input | NUM_CH | Mask bit, one per channel; it blocks the peripheral request lines |
| hi_pri | input | NUM_CH | High-priority group membership, one bit per channel |
| single_only | input | NUM_CH | 1 means the channel's burst is one move |
| single_req | input | NUM_CH | Peripheral single-request line, one per channel |
| burst_req | input | NUM_CH | Peripheral burst-request line, one per channel |
| sw_req | input | NUM_CH | Software-request pulse, one per channel |
| burst_exp | input | NUM_CH*EXP_W | Burst exponent of each channel; channel c uses bits [c*EXP_W +: EXP_W] |
| move_done | input | 1 | One data move completed |
| grant_valid | output | 1 | A channel holds the bus |
| grant_idx | output | IDX_W | Index of the granted channel |
| burst_start | output | 1 | Pulse on the first cycle of each grant |

## Verification
The assertions check these properties on every cycle:
- The index is held steady whenever no move completes.
- A new grant begins only at idle or on a completed move.
- The start strobe only ever appears together with a valid grant.
- A new grant goes only to a channel that was enabled.
- The index reads zero while the arbiter is idle.

Some properties need the full history of requests and move counts, and only the bench's scenarios can show them:
- The burst lasts the right number of moves.
- The group and index priority pick the right winner.
- Masking hides the peripheral request lines.
- One software pulse yields exactly one burst.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_t;
endpackage

// File: rtl/bpa_chan_qual.sv
module bpa_chan_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic mask,
  input  logic hi,
  input  logic sreq,
  input  logic breq,
  input  logic sw_pulse,
  input  logic sw_clear,
  output logic pend_hi,
  output logic pend_lo
);
  logic sw_q;
  logic sw_d;
  logic periph_req;
  logic pend;

  // A new pulse wins over the clear raised by a grant in the same cycle.
  always_comb begin
    sw_d = sw_pulse | (sw_q & ~sw_clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= 1'b0;
    end else begin
      sw_q <= sw_d;
    end
  end

  always_comb begin
    periph_req = (sreq | breq) & ~mask;
    pend       = en & (periph_req | sw_q);
    pend_hi    = pend & hi;
    pend_lo    = pend & ~hi;
  end
endmodule

// File: rtl/bpa_first_set.sv
module bpa_first_set #(
  parameter int NUM_CH = 16,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] vec,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  // Scan from the top index down so that the lowest set index is the last one written.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/bpa_move_cnt.sv
module bpa_move_cnt #(
  parameter int EXP_W = 4,
  localparam int CNT_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/burst_prio_arbiter.sv
module burst_prio_arbiter
  import bpa_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int EXP_W  = 4,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int CNT_W = (1 << EXP_W) - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH-1:0]       req_mask,
  input  logic [NUM_CH-1:0]       hi_pri,
  input  logic [NUM_CH-1:0]       single_only,
  input  logic [NUM_CH-1:0]       single_req,
  input  logic [NUM_CH-1:0]       burst_req,
  input  logic [NUM_CH-1:0]       sw_req,
  input  logic [NUM_CH*EXP_W-1:0] burst_exp,
  input  logic                    move_done,
  output logic                    grant_valid,
  output logic [IDX_W-1:0]        grant_idx,
  output logic                    burst_start
);
  logic [NUM_CH-1:0] pend_hi;
  logic [NUM_CH-1:0] pend_lo;
  logic [NUM_CH-1:0] sw_clear;
  logic              any_hi;
  logic              any_lo;
  logic [IDX_W-1:0]  idx_hi;
  logic [IDX_W-1:0]  idx_lo;
  logic              win_found;
  logic [IDX_W-1:0]  win_idx;
  logic              arb_pt;
  logic              take;
  logic              cnt_last;
  logic              cnt_dec;
  logic [CNT_W-1:0]  len_m1;
  logic [EXP_W-1:0]  win_exp;

  arb_state_t        state_q;
  arb_state_t        state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_d;
  logic              start_q;
  logic              start_d;

  // Per-channel qualification: enable, mask, group membership and the stored software request.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    bpa_chan_qual u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_en[c]),
      .mask     (req_mask[c]),
      .hi       (hi_pri[c]),
      .sreq     (single_req[c]),
      .breq     (burst_req[c]),
      .sw_pulse (sw_req[c]),
      .sw_clear (sw_clear[c]),
      .pend_hi  (pend_hi[c]),
      .pend_lo  (pend_lo[c])
    );
  end

  bpa_first_set #(.NUM_CH(NUM_CH)) u_pick_hi (
    .vec   (pend_hi),
    .found (any_hi),
    .idx   (idx_hi)
  );

  bpa_first_set #(.NUM_CH(NUM_CH)) u_pick_lo (
    .vec   (pend_lo),
    .found (any_lo),
    .idx   (idx_lo)
  );

  always_comb begin
    win_found = any_hi | any_lo;
    win_idx   = any_hi ? idx_hi : idx_lo;
  end

  // Burst length minus one for the winner: 0 for single-only channels, otherwise 2^N - 1.
  always_comb begin
    win_exp = burst_exp[win_idx*EXP_W +: EXP_W];
    if (single_only[win_idx]) begin
      len_m1 = '0;
    end else begin
      len_m1 = CNT_W'(({{CNT_W{1'b0}}, 1'b1} << win_exp) - 1'b1);
    end
  end

  // A decision is taken while idle, or on the last move of the current burst.
  always_comb begin
    arb_pt  = (state_q == ARB_IDLE) | (move_done & cnt_last);
    take    = arb_pt & win_found;
    cnt_dec = (state_q == ARB_BUSY) & move_done & ~cnt_last;
  end

  always_comb begin
    sw_clear = '0;
    if (take) begin
      sw_clear[win_idx] = 1'b1;
    end
  end

  bpa_move_cnt #(.EXP_W(EXP_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .load_val (len_m1),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  // Next-state logic for the grant.
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    start_d = 1'b0;
    if (arb_pt) begin
      if (win_found) begin
        state_d = ARB_BUSY;
        idx_d   = win_idx;
        start_d = 1'b1;
      end else begin
        state_d = ARB_IDLE;
        idx_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      idx_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      start_q <= start_d;
    end
  end

  assign grant_valid = (state_q == ARB_BUSY);
  assign grant_idx   = idx_q;
  assign burst_start = start_q;
endmodule

// File: rtl/burst_prio_arbiter_chk.sv
module burst_prio_arbiter_chk #(
  parameter int NUM_CH = 16,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_en,
  input logic              move_done,
  input logic              grant_valid,
  input logic [IDX_W-1:0]  grant_idx,
  input logic              burst_start
);
  logic [NUM_CH-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= ch_en;
    end
  end

  AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant_idx == '0)); // R10

  AST_START_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> grant_valid); // R11

  AST_HOLD_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !move_done) |=> (grant_valid && $stable(grant_idx) && !burst_start)); // R4

  AST_START_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && $past(grant_valid)) |-> $past(move_done)); // R4

  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> en_q[grant_idx]); // R9
endmodule

bind burst_prio_arbiter burst_prio_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch_en       (ch_en),
  .move_done   (move_done),
  .grant_valid (grant_valid),
  .grant_idx   (grant_idx),
  .burst_start (burst_start)
);

// File: tb/burst_prio_arbiter_test.sv
module burst_prio_arbiter_test;
  localparam int NCH   = 16;
  localparam int EW    = 4;
  localparam int IW    = $clog2(NCH);

  logic            clk;
  logic            rst_n;
  logic [NCH-1:0]  ch_en, req_mask, hi_pri, single_only, single_req, burst_req, sw_req;
  logic [NCH*EW-1:0] burst_exp;
  logic            move_done;
  logic            grant_valid;
  logic [IW-1:0]   grant_idx;
  logic            burst_start;

  burst_prio_arbiter #(.NUM_CH(NCH), .EXP_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .req_mask(req_mask), .hi_pri(hi_pri),
    .single_only(single_only), .single_req(single_req), .burst_req(burst_req),
    .sw_req(sw_req), .burst_exp(burst_exp), .move_done(move_done),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .burst_start(burst_start)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  int    cyc    = 0;
  bit    done   = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_valid, m_idx, m_start, m_left;
  bit m_sw [NCH];

  function automatic bit m_pend(int i);
    return ch_en[i] && ((!req_mask[i] && (single_req[i] || burst_req[i])) || m_sw[i]);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_valid = 0; m_idx = 0; m_start = 0; m_left = 0;
      for (int i = 0; i < NCH; i++) m_sw[i] = 0;
    end else begin
      bit boundary;
      int w;
      boundary = (m_valid == 0) || (move_done && m_left == 1);
      if (m_valid != 0 && move_done && m_left > 1) m_left--;
      m_start = 0;
      if (boundary) begin
        w = -1;
        for (int i = 0; i < NCH; i++) if (w < 0 && hi_pri[i] && m_pend(i)) w = i;
        for (int i = 0; i < NCH; i++) if (w < 0 && !hi_pri[i] && m_pend(i)) w = i;
        if (w >= 0) begin
          m_valid = 1; m_idx = w; m_start = 1;
          m_left = single_only[w] ? 1 : (1 << burst_exp[w*EW +: EW]);
          m_sw[w] = 0;
        end else begin
          m_valid = 0; m_idx = 0;
        end
      end
      for (int i = 0; i < NCH; i++) if (sw_req[i]) m_sw[i] = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      checks++;
      if (grant_valid !== 1'(m_valid) || grant_idx !== IW'(m_idx) || burst_start !== 1'(m_start)) begin
        errors++;
        $display("FAIL %s cycle %0d: valid/idx/start actual %0b/%0d/%0b expected %0d/%0d/%0d",
                 cur_req, cyc, grant_valid, grant_idx, burst_start, m_valid, m_idx, m_start);
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_exp(int ch, int v);
    burst_exp[ch*EW +: EW] = EW'(v);
  endtask

  task automatic clear_all();
    req_mask = '0; hi_pri = '0; single_only = '0; single_req = '0;
    burst_req = '0; sw_req = '0; burst_exp = '0; move_done = 1'b0;
    ch_en = '1;
  endtask

  task automatic pulse_sw(int ch);
    sw_req[ch] = 1'b1; step(1); sw_req[ch] = 1'b0;
  endtask

  task automatic chk(string r, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  initial begin
    int starts7;
    rst_n = 1'b0;
    clear_all();
    step(3);
    chk("R1", grant_valid === 1'b0, grant_valid, 0);
    chk("R1", grant_idx === '0, grant_idx, 0);
    chk("R1", burst_start === 1'b0, burst_start, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    step(2);

    // R2: fixed order, lowest index first
    cur_req = "R2";
    burst_req[5] = 1; burst_req[3] = 1; move_done = 1;
    step(3);
    chk("R2", grant_valid && grant_idx == 3, grant_idx, 3);
    burst_req = '0; step(4);

    // R3: high-priority group overrides index order
    cur_req = "R3";
    hi_pri[9] = 1; hi_pri[12] = 1;
    single_req[2] = 1; single_req[12] = 1; single_req[9] = 1;
    step(3);
    chk("R3", grant_valid && grant_idx == 9, grant_idx, 9);
    single_req[9] = 0; step(2);
    chk("R3", grant_valid && grant_idx == 12, grant_idx, 12);
    single_req = '0; hi_pri = '0; step(4);

    // R4: grant held for 2^N moves with sparse move strobes
    cur_req = "R4";
    move_done = 0;
    set_exp(1, 3); burst_req[1] = 1; burst_req[0] = 0;
    step(2);
    burst_req[0] = 1; // higher priority arrives mid-burst
    for (int k = 0; k < 8; k++) begin
      move_done = 1; step(1); move_done = 0; step(2);
      if (k < 7) chk("R4", grant_idx == 1, grant_idx, 1);
    end
    chk("R4", grant_idx == 0, grant_idx, 0);
    burst_req = '0; move_done = 1; step(4);

    // R5: same channel re-granted while still best
    cur_req = "R5";
    set_exp(4, 1); burst_req[4] = 1; burst_req[6] = 1;
    step(10);
    chk("R5", grant_idx == 4, grant_idx, 4);
    burst_req = '0; step(4);

    // R6: single-only ignores exponent
    cur_req = "R6";
    set_exp(2, 5); single_only[2] = 1; single_req[2] = 1; single_req[8] = 1;
    step(4);
    single_req[2] = 0; step(2);
    chk("R6", grant_idx == 8, grant_idx, 8);
    single_req = '0; single_only = '0; step(4);

    // R7: mask hides peripheral lines
    cur_req = "R7";
    req_mask[3] = 1; burst_req[3] = 1; single_req[3] = 1; burst_req[10] = 1;
    step(4);
    chk("R7", grant_idx == 10, grant_idx, 10);
    burst_req[10] = 0; step(3);
    chk("R7", grant_valid == 0, grant_valid, 0);
    burst_req = '0; single_req = '0; step(2);

    // R8: software request on masked channel yields exactly one burst
    cur_req = "R8";
    req_mask[7] = 1; set_exp(7, 2); move_done = 0;
    starts7 = 0;
    pulse_sw(7);
    for (int k = 0; k < 30; k++) begin
      if (k % 3 == 0) move_done = 1; else move_done = 0;
      step(1);
      if (burst_start && grant_idx == 7) starts7++;
    end
    chk("R8", starts7 == 1, starts7, 1);
    move_done = 1; req_mask = '0; step(3);

    // R9: disabled channel never granted
    cur_req = "R9";
    ch_en[1] = 0; burst_req[1] = 1; pulse_sw(1); burst_req[11] = 1;
    step(5);
    chk("R9", grant_idx == 11, grant_idx, 11);
    burst_req = '0; step(4);

    // R10: idle when nothing pending
    cur_req = "R10";
    chk("R10", grant_valid == 0 && grant_idx == 0, grant_idx, 0);
    ch_en = '1; step(3);

    // R11 and mixed: random stimulus under the cycle model
    cur_req = "R11";
    for (int k = 0; k < 3000; k++) begin
      ch_en       = NCH'($urandom) | NCH'($urandom);
      req_mask    = NCH'($urandom) & NCH'($urandom);
      hi_pri      = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      single_only = NCH'($urandom) & NCH'($urandom);
      single_req  = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      burst_req   = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      sw_req      = ($urandom % 8 == 0) ? NCH'(1 << ($urandom % NCH)) : '0;
      for (int c = 0; c < NCH; c++) set_exp(c, $urandom % 3);
      move_done   = ($urandom % 4) != 0;
      step(1);
    end
    clear_all(); move_done = 1;
    step(80);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule